// File: doc/BRIEF.md
# SPI Register-Access Command Slave

This block is an SPI slave (clock idle low, data captured on the rising SCLK edge, most significant bit first). It gives an SPI master access to a 128-byte register file that controls a bus-controller peripheral. Each transaction starts when chip select goes low. The first byte is an opcode, and the block decodes it into one of five commands: write, read, masked bit modify, soft reset, or quick status read. Reads and writes run as bursts, and the register address advances by one after every data byte. The address wraps from the top of the file back to zero.

The SPI pins are synchronised into the system clock domain, so SCLK must be slow compared with `clk_i`. A parallel host port lets the surrounding logic write any register and read any register combinationally. The upper three bits of the control register are presented as the operating-mode output. The quick status byte comes straight from the `status_i` pins.

Top module: `spi_regcmd_slave`

## Requirements
- R1: Opcode 0x02, an address byte and N data bytes write the data bytes to address, address+1, and so on up to address+N-1.
- R2: Opcode 0x03 and an address byte cause every later byte on MISO to carry the register at the current address, MSB first, after which the address advances. MISO is driven on falling SCLK so that it is valid for the next rising edge.
- R3: Opcode 0x05, an address, a mask and a data byte replace only the bits that are set in the mask. Every other bit of that register is unchanged, and any later bytes in the transaction have no effect.
- R4: Opcode 0xC0 and `rst_ni` both return the register file to its defaults: 0x80 at the control address 0x0F and zero everywhere else. As a result, `mode_o` reads 3'b100 (configuration).
- R5: Opcode 0xA0 puts the value of `status_i` on MISO in the next byte, with no address byte. Any further bytes in that transaction return zero.
- R6: A rising chip select ends the transaction. Bytes that were already complete keep their effect, and a partial byte changes no register.
- R7: Bits [7:5] of register 0x0F form the mode field, with values 0x80 configuration, 0x00 normal, 0x40 loopback, 0x60 listen-only and 0x20 sleep. Any value written reads back unchanged over SPI, and `mode_o` shows the field.
- R8: The burst address wraps from 0x7F to 0x00, for reads and for writes.
- R9: An unknown opcode changes no register for the rest of the transaction, and MISO stays zero during it.
- R10: A host-port write is visible to later SPI reads, and `host_rdata_o` shows any register that was written over SPI. If both ports write in the same cycle, the SPI write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | Serial data from master |
| spi_miso_o | output | 1 | Serial data to master |
| status_i | input | 8 | Flags returned by the quick status command |
| host_we_i | input | 1 | Host-port write strobe |
| host_addr_i | input | 7 | Host-port register address |
| host_wdata_i | input | 8 | Host-port write data |
| host_rdata_o | output | 8 | Register at host_addr_i |
| mode_o | output | 3 | Mode field of the control register |

## Verification
The bench uses the default parameters: a 7-bit address and 8-bit data, which give the full 128-entry file, and two synchroniser stages. The file size makes the 0x7F-to-0x00 wrap, a full post-reset scan, and the real control address 0x0F all reachable within one short run. SCLK runs at one twentieth of the system clock. This leaves room for the synchroniser and the byte-completion register latency before the master samples MISO, so the first bit of each read byte is tested under realistic margin. Partial-byte aborts, unknown opcodes and bit-modify transactions with trailing bytes are mixed with random write and read bursts that are checked against a reference model of the register file.

// File: rtl/spi_regcmd_pkg.sv
package spi_regcmd_pkg;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_BITMOD = 8'h05;
  localparam logic [7:0] OP_STATUS = 8'hA0;
  localparam logic [7:0] OP_RESET  = 8'hC0;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_STREAM,
    ST_MASK,
    ST_BMDATA,
    ST_IGNORE
  } cmd_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_o,
  output logic mosi_o
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;
  localparam logic [2:0] PIN_RST = 3'b010; // {mosi, cs, sclk}

  logic [NS-1:0][2:0] stg_q;
  logic               sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q       <= {NS{PIN_RST}};
      sclk_prev_q <= 1'b0;
    end else begin
      stg_q       <= {stg_q[NS-2:0], {mosi_i, cs_ni, sclk_i}};
      sclk_prev_q <= stg_q[NS-1][0];
    end
  end

  assign sclk_rise_o = stg_q[NS-1][0] & ~sclk_prev_q;
  assign sclk_fall_o = ~stg_q[NS-1][0] & sclk_prev_q;
  assign cs_o        = stg_q[NS-1][1];
  assign mosi_o      = stg_q[NS-1][2];
endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile #(
  parameter int              ADDR_W    = 7,
  parameter int              DATA_W    = 8,
  parameter int              CTRL_ADDR = 15,
  parameter logic [DATA_W-1:0] CTRL_RST = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              spi_we_i,
  input  logic [ADDR_W-1:0] spi_addr_i,
  input  logic [DATA_W-1:0] spi_mask_i,
  input  logic [DATA_W-1:0] spi_wdata_i,
  input  logic [ADDR_W-1:0] spi_raddr_i,
  output logic [DATA_W-1:0] spi_rdata_o,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [DEPTH];
  logic [DATA_W-1:0] spi_cur;
  logic [DATA_W-1:0] spi_merged;

  function automatic logic [DATA_W-1:0] rst_val(int idx);
    return (idx == CTRL_ADDR) ? CTRL_RST : '0;
  endfunction

  assign spi_cur    = regs_q[spi_addr_i];
  assign spi_merged = (spi_cur & ~spi_mask_i) | (spi_wdata_i & spi_mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= rst_val(i);
    end else if (soft_rst_i) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= rst_val(i);
    end else begin
      if (host_we_i) regs_q[host_addr_i] <= host_wdata_i;
      // later assignment wins: SPI over host
      if (spi_we_i)  regs_q[spi_addr_i]  <= spi_merged;
    end
  end

  assign spi_rdata_o  = regs_q[spi_raddr_i];
  assign host_rdata_o = regs_q[host_addr_i];
  assign ctrl_o       = regs_q[CTRL_ADDR];

  // R4
  soft_rst_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (ctrl_o == CTRL_RST));

  // R3
  bitmod_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_we_i && !soft_rst_i) |=>
      ((regs_q[$past(spi_addr_i)] & ~$past(spi_mask_i)) ==
       ($past(spi_cur) & ~$past(spi_mask_i))));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_regcmd_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              soft_rst_o,
  output logic              miso_o
);
  localparam int              BIT_W    = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  cmd_state_e        state_q, state_d;
  logic [DATA_W-1:0] cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_sr_q, tx_sr_q;
  logic [DATA_W-1:0] rx_byte, tx_val;
  logic              byte_done, addr_inc;

  assign rx_byte   = {rx_sr_q[DATA_W-2:0], mosi_i};
  assign byte_done = !cs_i && sclk_rise_i && (bit_cnt_q == LAST_BIT);

  always_comb begin
    state_d    = state_q;
    cmd_d      = cmd_q;
    addr_d     = addr_q;
    mask_d     = mask_q;
    tx_val     = '0;
    we_o       = 1'b0;
    waddr_o    = addr_q;
    mask_o     = '1;
    wdata_o    = rx_byte;
    raddr_o    = addr_q;
    soft_rst_o = 1'b0;
    addr_inc   = 1'b0;
    if (byte_done) begin
      unique case (state_q)
        ST_OPC: begin
          cmd_d = rx_byte;
          unique case (rx_byte)
            OP_WRITE, OP_READ, OP_BITMOD: state_d = ST_ADDR;
            OP_STATUS: begin
              tx_val  = status_i;
              state_d = ST_IGNORE;
            end
            OP_RESET: begin
              soft_rst_o = 1'b1;
              state_d    = ST_IGNORE;
            end
            default: state_d = ST_IGNORE;
          endcase
        end
        ST_ADDR: begin
          addr_d = rx_byte[ADDR_W-1:0];
          if (cmd_q == OP_READ) begin
            raddr_o = rx_byte[ADDR_W-1:0];
            tx_val  = rdata_i;
            addr_d  = rx_byte[ADDR_W-1:0] + ADDR_W'(1);
            state_d = ST_STREAM;
          end else if (cmd_q == OP_WRITE) begin
            state_d = ST_STREAM;
          end else begin
            state_d = ST_MASK;
          end
        end
        ST_STREAM: begin
          addr_inc = 1'b1;
          addr_d   = addr_q + ADDR_W'(1);
          if (cmd_q == OP_WRITE) we_o = 1'b1;
          else                   tx_val = rdata_i;
        end
        ST_MASK: begin
          mask_d  = rx_byte;
          state_d = ST_BMDATA;
        end
        ST_BMDATA: begin
          we_o    = 1'b1;
          mask_o  = mask_q;
          state_d = ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OPC;
      cmd_q     <= '0;
      addr_q    <= '0;
      mask_q    <= '0;
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
    end else if (cs_i) begin
      state_q   <= ST_OPC;
      bit_cnt_q <= '0;
      tx_sr_q   <= '0;
    end else begin
      if (sclk_rise_i) begin
        rx_sr_q   <= rx_byte;
        bit_cnt_q <= bit_cnt_q + BIT_W'(1);
      end
      if (byte_done) begin
        tx_sr_q <= tx_val;
        state_q <= state_d;
        cmd_q   <= cmd_d;
        addr_q  <= addr_d;
        mask_q  <= mask_d;
      end else if (sclk_fall_i && bit_cnt_q != '0) begin
        tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = tx_sr_q[DATA_W-1];

  // R6
  desel_tx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i |=> (tx_sr_q == '0));

  // R6
  bit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !sclk_rise_i) |=> (bit_cnt_q == $past(bit_cnt_q)));

  // R9
  we_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (cmd_q == OP_WRITE || cmd_q == OP_BITMOD));

  // R8
  addr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_inc && addr_q == '1) |=> (addr_q == '0));
endmodule

// File: rtl/spi_regcmd_slave.sv
module spi_regcmd_slave #(
  parameter int              ADDR_W      = 7,
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter int              CTRL_ADDR   = 15,
  parameter logic [DATA_W-1:0] CTRL_RST  = 8'h80,
  parameter int              MODE_W      = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  input  logic [DATA_W-1:0] status_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [MODE_W-1:0] mode_o
);
  logic              sclk_rise, sclk_fall, cs_sync, mosi_sync;
  logic              spi_we, soft_rst, miso_raw;
  logic [ADDR_W-1:0] spi_waddr, spi_raddr;
  logic [DATA_W-1:0] spi_mask, spi_wdata, spi_rdata, ctrl;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (spi_sclk_i),
    .cs_ni      (spi_cs_ni),
    .mosi_i     (spi_mosi_i),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .cs_o       (cs_sync),
    .mosi_o     (mosi_sync)
  );

  spi_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .cs_i       (cs_sync),
    .mosi_i     (mosi_sync),
    .status_i   (status_i),
    .rdata_i    (spi_rdata),
    .raddr_o    (spi_raddr),
    .we_o       (spi_we),
    .waddr_o    (spi_waddr),
    .mask_o     (spi_mask),
    .wdata_o    (spi_wdata),
    .soft_rst_o (soft_rst),
    .miso_o     (miso_raw)
  );

  cmd_regfile #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR),
    .CTRL_RST (CTRL_RST)
  ) u_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst),
    .spi_we_i    (spi_we),
    .spi_addr_i  (spi_waddr),
    .spi_mask_i  (spi_mask),
    .spi_wdata_i (spi_wdata),
    .spi_raddr_i (spi_raddr),
    .spi_rdata_o (spi_rdata),
    .host_we_i   (host_we_i),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .ctrl_o      (ctrl)
  );

  assign spi_miso_o = cs_sync ? 1'b0 : miso_raw;
  assign mode_o     = ctrl[DATA_W-1 -: MODE_W];
endmodule

// File: tb/sim_spi_regcmd_slave.sv
module sim_spi_regcmd_slave;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [7:0] status = '0;
  logic       host_we = 1'b0;
  logic [6:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [2:0] mode;

  logic [7:0] model [128];
  logic [7:0] tx_b [32];
  logic [7:0] rx_b [32];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_regcmd_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_cs_ni(cs_n),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .status_i(status),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .mode_o(mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bm(input logic [7:0] cur, input logic [7:0] m, input logic [7:0] d);
    return (cur & ~m) | (d & m);
  endfunction

  task automatic xfer(input int nbytes, input int part_bits);
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbytes + (part_bits > 0 ? 1 : 0); b++) begin
      rx_b[b] = '0;
      for (int k = 7; k >= 0; k--) begin
        if (b == nbytes && k <= 7 - part_bits) break;
        mosi = tx_b[b][k];
        repeat (HALF) @(negedge clk);
        rx_b[b][k] = miso;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic host_rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk) host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic host_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk) begin host_addr = a; host_wdata = d; host_we = 1'b1; end
    @(negedge clk) host_we = 1'b0;
    model[a] = d;
  endtask

  task automatic spi_write(input logic [6:0] a, input int n);
    tx_b[0] = 8'h02; tx_b[1] = {1'b0, a};
    for (int i = 0; i < n; i++) begin
      tx_b[2 + i] = 8'($urandom);
      model[7'(a + i)] = tx_b[2 + i];
    end
    xfer(n + 2, 0);
  endtask

  task automatic spi_read_chk(input string tag, input logic [6:0] a, input int n);
    tx_b[0] = 8'h03; tx_b[1] = {1'b0, a};
    for (int i = 0; i < n; i++) tx_b[2 + i] = 8'($urandom);
    xfer(n + 2, 0);
    for (int i = 0; i < n; i++) check(tag, rx_b[2 + i], model[7'(a + i)]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] modes [5];
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) model[i] = (i == 15) ? 8'h80 : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 reset state
    check("R4 mode after reset", {5'b0, mode}, 8'h04);
    host_rd(7'h0F, d); check("R4 ctrl after reset", d, 8'h80);
    host_rd(7'h33, d); check("R4 other after reset", d, 8'h00);

    // R1 burst write, R10 seen on host port
    spi_write(7'h10, 4);
    for (int i = 0; i < 4; i++) begin
      host_rd(7'(7'h10 + i), d); check("R1 burst write", d, model[7'h10 + i]);
    end
    // R2 burst read
    spi_read_chk("R2 burst read", 7'h10, 4);

    // R8 wrap on write and read
    spi_write(7'h7E, 3);
    host_rd(7'h00, d); check("R8 write wrap", d, model[0]);
    host_rd(7'h7F, d); check("R8 write top", d, model[127]);
    spi_read_chk("R8 read wrap", 7'h7F, 2);

    // R3 bit modify with trailing byte ignored
    host_wr(7'h20, 8'hA5);
    host_wr(7'h21, 8'h3C);
    tx_b[0] = 8'h05; tx_b[1] = 8'h20; tx_b[2] = 8'h3C; tx_b[3] = 8'h5A; tx_b[4] = 8'hFF;
    xfer(5, 0);
    model[7'h20] = bm(8'hA5, 8'h3C, 8'h5A);
    host_rd(7'h20, d); check("R3 bit modify", d, model[7'h20]);
    host_rd(7'h21, d); check("R3 neighbour untouched", d, 8'h3C);
    check("R3 expected value", model[7'h20], 8'h99);

    // R7 mode field round trip
    modes[0] = 8'h00; modes[1] = 8'h40; modes[2] = 8'h60; modes[3] = 8'h20; modes[4] = 8'h80;
    for (int m = 0; m < 5; m++) begin
      tx_b[0] = 8'h02; tx_b[1] = 8'h0F; tx_b[2] = modes[m];
      xfer(3, 0);
      model[15] = modes[m];
      spi_read_chk("R7 mode readback", 7'h0F, 1);
      check("R7 mode_o", {5'b0, mode}, {5'b0, modes[m][7:5]});
    end

    // R5 quick status
    status = 8'($urandom);
    tx_b[0] = 8'hA0; tx_b[1] = 8'h00; tx_b[2] = 8'h00;
    xfer(3, 0);
    check("R5 status byte", rx_b[1], status);
    check("R5 trailing byte", rx_b[2], 8'h00);

    // R6 abort with partial byte
    host_wr(7'h30, 8'h11);
    tx_b[0] = 8'h02; tx_b[1] = 8'h30; tx_b[2] = 8'hEE;
    xfer(2, 5);
    host_rd(7'h30, d); check("R6 partial discarded", d, 8'h11);
    host_wr(7'h32, 8'h22);
    tx_b[0] = 8'h02; tx_b[1] = 8'h31; tx_b[2] = 8'hAA; tx_b[3] = 8'hCC;
    xfer(3, 3);
    model[7'h31] = 8'hAA;
    host_rd(7'h31, d); check("R6 full byte kept", d, 8'hAA);
    host_rd(7'h32, d); check("R6 partial after full", d, 8'h22);

    // R9 unknown opcode
    host_wr(7'h40, 8'h5C);
    tx_b[0] = 8'h77; tx_b[1] = 8'h40; tx_b[2] = 8'h55; tx_b[3] = 8'h02;
    xfer(4, 0);
    for (int i = 0; i < 4; i++) check("R9 miso zero", rx_b[i], 8'h00);
    host_rd(7'h40, d); check("R9 register kept", d, 8'h5C);

    // R10 host write seen by SPI read
    host_wr(7'h50, 8'h3C);
    spi_read_chk("R10 host to spi", 7'h50, 1);

    // random bursts and bit modifies
    for (int it = 0; it < 15; it++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom);
      n = 1 + int'($urandom % 5);
      if ($urandom % 3 == 0) begin
        tx_b[0] = 8'h05; tx_b[1] = {1'b0, a}; tx_b[2] = 8'($urandom); tx_b[3] = 8'($urandom);
        xfer(4, 0);
        model[a] = bm(model[a], tx_b[2], tx_b[3]);
        spi_read_chk("R3 random bit modify", a, 1);
      end else begin
        spi_write(a, n);
        spi_read_chk("R1 R2 random burst", a, n);
      end
    end

    // R4 reset opcode
    tx_b[0] = 8'hC0; tx_b[1] = 8'h00;
    xfer(2, 0);
    for (int i = 0; i < 128; i++) begin
      host_rd(7'(i), d);
      check("R4 soft reset scan", d, (i == 15) ? 8'h80 : 8'h00);
    end
    check("R4 mode after soft reset", {5'b0, mode}, 8'h04);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule